// File: doc/BRIEF.md
# Lockable Watchdog Timer

This block is a watchdog for a microcontroller. It counts ticks from one of two per-cycle enables, a slow internal oscillator tick or a system clock tick. When the count reaches a power-of-two period picked by software, it pulses a reset request for one cycle. Software keeps the request from firing by writing a key value to a refresh register. Writing any other value to that register forces the request at once.

A five-bit mode field sets two things: the tick source (slow, system, or stopped) and a three-bit period exponent. Each source applies its own offset to that exponent. After reset the field takes exactly one write and ignores every later write, so a runaway program cannot change the watchdog setting. A static strap input can force the slow source whatever was written to the source field. The oscillators, the reset controller and the strap storage sit outside the block.

The register bus is minimal: a write strobe, a one-bit address, 8-bit write data, and read data that follows the address combinationally. Address 0 is the mode register and address 1 is the refresh register.

Top module: `wdt_lockable`

## Requirements
- R1: After reset, reading address 0 returns 0x67 and the reset request is low.
- R2: Reading address 0 returns 0b011 in bits 7:5 and the mode field in bits 4:0. Reading address 1 returns 0x00.
- R3: The first write to address 0 after reset loads bits 4:0 into the mode field. Every later write to address 0 leaves the field unchanged until the next reset.
- R4: Mode bits 4:3 choose the source: 00 selects the slow tick and 01 selects the system tick. The counter advances only on cycles where the selected tick is high.
- R5: With the slow source and bits 2:0 equal to n, the request is high in the cycle after the 2^(11+n)-th counted tick, and the count then restarts from zero.
- R6: With the system source and bits 2:0 equal to n, the request follows the 2^(13+n)-th counted tick in the same way.
- R7: With mode bits 4:3 equal to 1x and the strap low, the counter stays at zero and no request is raised, not even on a wrong refresh key.
- R8: While the strap input keep_slow is high, the slow tick drives the counter for every value of bits 4:3, including 1x.
- R9: Writing 0xAC to address 1 clears the counter without raising a request.
- R10: Writing any value other than 0xAC to address 1 raises the request in the next cycle and clears the counter.
- R11: An accepted mode write clears the counter, so the new period starts from zero.
- R12: Each overflow makes the request high for exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 1 | Register select: 0 is mode, 1 is refresh |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the selected register |
| slow_tick | input | 1 | Per-cycle enable from the slow internal oscillator |
| sys_tick | input | 1 | Per-cycle enable from the system clock divider |
| keep_slow | input | 1 | Strap: forces the slow source so the watchdog cannot be stopped |
| wdt_rst_req | output | 1 | One-cycle reset request |

## Verification
The hardest state to reach is an overflow at the exact period boundary. The mode field can be written only once per reset, so every setting needs its own reset, and the shortest period is still 2048 ticks. The bench therefore resets before each setting, programs the shortest exponents, and holds the chosen tick high for a known number of cycles. It checks that the request is still low one tick before the boundary, high on the boundary, and low again one cycle later. A randomized phase with short periods and random key writes then covers clears that land near the boundary.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    localparam int MODE_W = 5;
    localparam logic [MODE_W-1:0] MODE_RST = 5'b00111;

    typedef enum logic [1:0] {
        SRC_SLOW = 2'b00,
        SRC_SYS  = 2'b01,
        SRC_OFF  = 2'b10
    } wdt_src_e;

    typedef struct packed {
        logic [MODE_W-1:0] field;
        logic              locked;
    } mode_state_t;

endpackage

// File: rtl/wdt_mode_lock.sv
module wdt_mode_lock
    import wdt_pkg::*;
#(
    parameter int                W       = MODE_W,
    parameter logic [W-1:0]      RST_VAL = MODE_RST
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_mode,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] field,
    output logic         wr_accept
);

    typedef struct packed {
        logic [W-1:0] field;
        logic         locked;
    } lock_state_t;

    lock_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        wr_accept = wr_mode && !st_q.locked;
        if (wr_accept) begin
            st_d.field  = wdata;
            st_d.locked = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.field  <= RST_VAL;
            st_q.locked <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign field = st_q.field;

    // R3: once locked, the field no longer changes
    assert_write_once_R3: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.locked |=> $stable(st_q.field));

    // R3: the lock stays set until reset
    assert_lock_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.locked |=> st_q.locked);

endmodule

// File: rtl/wdt_src_sel.sv
module wdt_src_sel
    import wdt_pkg::*;
#(
    parameter int CNT_W     = 20,
    parameter int SLOW_BASE = 11,
    parameter int FAST_BASE = 13
) (
    input  logic [MODE_W-1:0] field,
    input  logic              keep_slow,
    input  logic              slow_tick,
    input  logic              sys_tick,
    output logic              tick_en,
    output logic              halted,
    output logic [CNT_W-1:0]  cnt_last
);

    wdt_src_e src;
    int       exp_v;

    always_comb begin
        if (keep_slow)       src = SRC_SLOW;
        else if (field[4])   src = SRC_OFF;
        else if (field[3])   src = SRC_SYS;
        else                 src = SRC_SLOW;

        exp_v = ((src == SRC_SYS) ? FAST_BASE : SLOW_BASE) + int'(field[2:0]);

        unique case (src)
            SRC_SLOW: tick_en = slow_tick;
            SRC_SYS:  tick_en = sys_tick;
            default:  tick_en = 1'b0;
        endcase

        halted = (src == SRC_OFF);

        for (int i = 0; i < CNT_W; i++) begin
            cnt_last[i] = (i < exp_v);
        end
    end

endmodule

// File: rtl/wdt_count_core.sv
module wdt_count_core #(
    parameter int CNT_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic             halted,
    input  logic             clear,
    input  logic             bad_key,
    input  logic [CNT_W-1:0] cnt_last,
    output logic             req
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             req;
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.req = 1'b0;
        if (halted) begin
            st_d.cnt = '0;
        end else begin
            if (bad_key) begin
                st_d.req = 1'b1;
            end
            if (clear) begin
                st_d.cnt = '0;
            end else if (tick_en) begin
                if (st_q.cnt == cnt_last) begin
                    st_d.cnt = '0;
                    st_d.req = 1'b1;
                end else begin
                    st_d.cnt = st_q.cnt + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cnt <= '0;
            st_q.req <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign req = st_q.req;

    // R10: a wrong key raises the request one cycle later
    assert_bad_key_req_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (bad_key && !halted) |=> st_q.req);

    // R7: the stopped setting keeps the count at zero and stays quiet
    assert_stop_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> (!st_q.req && st_q.cnt == '0));

    // R5, R6: the count never passes the selected terminal value (strap assumed static)
    assert_cnt_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= cnt_last);

    // R4: without a tick or a clear the count holds
    assert_hold_no_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!halted && !clear && !tick_en) |=> $stable(st_q.cnt));

    // R12: a request always coincides with a restarted count
    assert_req_wrap_R12: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.req |-> (st_q.cnt == '0));

endmodule

// File: rtl/wdt_lockable.sv
module wdt_lockable
    import wdt_pkg::*;
#(
    parameter int                 CNT_W     = 20,
    parameter int                 DATA_W    = 8,
    parameter int                 SLOW_BASE = 11,
    parameter int                 FAST_BASE = 13,
    parameter logic [DATA_W-1:0]  KICK_KEY  = 8'hAC,
    parameter logic [DATA_W-1:0]  RD_FIXED  = 8'h60
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              slow_tick,
    input  logic              sys_tick,
    input  logic              keep_slow,
    output logic              wdt_rst_req
);

    localparam logic ADDR_MODE = 1'b0;
    localparam logic ADDR_KICK = 1'b1;
    localparam int   HI_W      = DATA_W - MODE_W;

    logic               wr_mode;
    logic               wr_kick;
    logic               mode_accept;
    logic [MODE_W-1:0]  mode_field;
    logic               tick_en;
    logic               halted;
    logic [CNT_W-1:0]   cnt_last;
    logic               clear;
    logic               bad_key;

    assign wr_mode = bus_wr && (bus_addr == ADDR_MODE);
    assign wr_kick = bus_wr && (bus_addr == ADDR_KICK);
    assign bad_key = wr_kick && (bus_wdata != KICK_KEY);
    assign clear   = mode_accept || wr_kick;

    wdt_mode_lock #(
        .W       (MODE_W),
        .RST_VAL (MODE_RST)
    ) u_mode (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_mode   (wr_mode),
        .wdata     (bus_wdata[MODE_W-1:0]),
        .field     (mode_field),
        .wr_accept (mode_accept)
    );

    wdt_src_sel #(
        .CNT_W     (CNT_W),
        .SLOW_BASE (SLOW_BASE),
        .FAST_BASE (FAST_BASE)
    ) u_src (
        .field     (mode_field),
        .keep_slow (keep_slow),
        .slow_tick (slow_tick),
        .sys_tick  (sys_tick),
        .tick_en   (tick_en),
        .halted    (halted),
        .cnt_last  (cnt_last)
    );

    wdt_count_core #(
        .CNT_W (CNT_W)
    ) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_en  (tick_en),
        .halted   (halted),
        .clear    (clear),
        .bad_key  (bad_key),
        .cnt_last (cnt_last),
        .req      (wdt_rst_req)
    );

    assign bus_rdata = (bus_addr == ADDR_MODE) ? (RD_FIXED | {{HI_W{1'b0}}, mode_field})
                                               : '0;

    // R11: an accepted mode write is never followed by an immediate overflow
    assert_mode_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_accept && !bad_key) |=> !wdt_rst_req);

endmodule

// File: tb/wdt_lockable_tb.sv
`timescale 1ns/1ps
module wdt_lockable_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0;
    logic       bus_addr = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       slow_tick = 1'b0;
    logic       sys_tick = 1'b0;
    logic       keep_slow = 1'b0;
    logic       wdt_rst_req;

    int checks = 0;
    int errors = 0;

    // bench reference state
    int m_mode;
    bit m_locked;
    int m_cnt;
    bit m_req;
    int req_seen;

    always #2.5 clk = ~clk;

    wdt_lockable u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_wr      (bus_wr),
        .bus_addr    (bus_addr),
        .bus_wdata   (bus_wdata),
        .bus_rdata   (bus_rdata),
        .slow_tick   (slow_tick),
        .sys_tick    (sys_tick),
        .keep_slow   (keep_slow),
        .wdt_rst_req (wdt_rst_req)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int exp_rdata();
        return bus_addr ? 0 : (32'h60 | m_mode);
    endfunction

    function automatic int period_of(input int mode, input bit strap);
        bit use_sys;
        use_sys = !strap && ((mode >> 3) & 3) == 1;
        return 1 << ((use_sys ? 13 : 11) + (mode & 7));
    endfunction

    task automatic model_clock();
        bit stopped, use_sys, tick, mode_w, kick_w;
        int nxt_cnt;
        bit nxt_req;
        stopped = !keep_slow && ((m_mode >> 4) & 1);
        use_sys = !keep_slow && ((m_mode >> 3) & 3) == 1;
        tick    = use_sys ? sys_tick : slow_tick;
        mode_w  = bus_wr && !bus_addr && !m_locked;
        kick_w  = bus_wr && bus_addr;
        nxt_cnt = m_cnt;
        nxt_req = 1'b0;
        if (stopped) begin
            nxt_cnt = 0;
        end else begin
            if (kick_w && bus_wdata != 8'hAC) nxt_req = 1'b1;
            if (mode_w || kick_w) nxt_cnt = 0;
            else if (tick) begin
                if (m_cnt == period_of(m_mode, keep_slow) - 1) begin
                    nxt_cnt = 0;
                    nxt_req = 1'b1;
                end else begin
                    nxt_cnt = m_cnt + 1;
                end
            end
        end
        if (mode_w) begin
            m_mode   = bus_wdata & 8'h1F;
            m_locked = 1'b1;
        end
        m_cnt = nxt_cnt;
        m_req = nxt_req;
    endtask

    task automatic step(input bit wr, input bit a, input logic [7:0] d,
                        input bit st, input bit yt);
        bus_wr    = wr;
        bus_addr  = a;
        bus_wdata = d;
        slow_tick = st;
        sys_tick  = yt;
        @(posedge clk);
        model_clock();
        @(negedge clk);
        if (wdt_rst_req) req_seen++;
        check("R12 request vs model", int'(wdt_rst_req), int'(m_req));
        check("R2 readback vs model", int'(bus_rdata), exp_rdata());
    endtask

    task automatic idle(input int n, input bit st, input bit yt);
        for (int i = 0; i < n; i++) step(1'b0, 1'b0, 8'h00, st, yt);
    endtask

    task automatic do_reset(input bit strap);
        rst_n     = 1'b0;
        keep_slow = strap;
        bus_wr    = 1'b0;
        bus_addr  = 1'b0;
        bus_wdata = 8'h00;
        slow_tick = 1'b0;
        sys_tick  = 1'b0;
        @(posedge clk);
        @(posedge clk);
        m_mode = 7; m_locked = 1'b0; m_cnt = 0; m_req = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check("R1 reset readback", int'(bus_rdata), 32'h67);
        check("R1 reset request", int'(wdt_rst_req), 0);
    endtask

    initial begin
        #(5.0 * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));

        // R1: defaults, long slow period, no request within 3000 ticks
        do_reset(1'b0);
        req_seen = 0;
        idle(3000, 1'b1, 1'b1);
        check("R1 default period not reached", req_seen, 0);

        // R2, R3, R4, R5, R12: slow source, n = 0
        do_reset(1'b0);
        step(1'b1, 1'b0, 8'hE0, 1'b0, 1'b0);
        check("R3 first write taken", int'(bus_rdata), 32'h60);
        step(1'b1, 1'b0, 8'h1F, 1'b0, 1'b0);
        check("R3 second write ignored", int'(bus_rdata), 32'h60);
        step(1'b0, 1'b1, 8'h00, 1'b0, 1'b0);
        check("R2 refresh address reads zero", int'(bus_rdata), 0);
        idle(2047, 1'b1, 1'b1);
        check("R5 no request one tick early", int'(wdt_rst_req), 0);
        idle(5, 1'b0, 1'b1);
        check("R4 system tick ignored on slow source", int'(wdt_rst_req), 0);
        step(1'b0, 1'b0, 8'h00, 1'b1, 1'b0);
        check("R5 request at 2^11 ticks", int'(wdt_rst_req), 1);
        step(1'b0, 1'b0, 8'h00, 1'b0, 1'b0);
        check("R12 request lasts one cycle", int'(wdt_rst_req), 0);

        // R6, R4: system source, n = 0
        do_reset(1'b0);
        step(1'b1, 1'b0, 8'h08, 1'b0, 1'b0);
        idle(8191, 1'b0, 1'b1);
        check("R6 no request one tick early", int'(wdt_rst_req), 0);
        idle(10, 1'b1, 1'b0);
        check("R4 slow tick ignored on system source", int'(wdt_rst_req), 0);
        step(1'b0, 1'b0, 8'h00, 1'b0, 1'b1);
        check("R6 request at 2^13 ticks", int'(wdt_rst_req), 1);

        // R8: strap forces the slow source over system and stop settings
        do_reset(1'b1);
        step(1'b1, 1'b0, 8'h08, 1'b0, 1'b0);
        check("R8 readback keeps written field", int'(bus_rdata), 32'h68);
        idle(2047, 1'b1, 1'b1);
        step(1'b0, 1'b0, 8'h00, 1'b1, 1'b0);
        check("R8 strap uses slow tick over system", int'(wdt_rst_req), 1);
        do_reset(1'b1);
        step(1'b1, 1'b0, 8'h10, 1'b0, 1'b0);
        idle(2047, 1'b1, 1'b0);
        step(1'b0, 1'b0, 8'h00, 1'b1, 1'b0);
        check("R8 strap runs despite stop setting", int'(wdt_rst_req), 1);

        // R7: stopped watchdog stays quiet
        do_reset(1'b0);
        step(1'b1, 1'b0, 8'h18, 1'b0, 1'b0);
        req_seen = 0;
        idle(5000, 1'b1, 1'b1);
        step(1'b1, 1'b1, 8'h00, 1'b1, 1'b1);
        check("R7 wrong key ignored while stopped", int'(wdt_rst_req), 0);
        check("R7 no request while stopped", req_seen, 0);

        // R11: accepted mode write restarts the count
        do_reset(1'b0);
        idle(2000, 1'b1, 1'b0);
        step(1'b1, 1'b0, 8'h00, 1'b0, 1'b0);
        idle(2047, 1'b1, 1'b0);
        check("R11 no early request after mode write", int'(wdt_rst_req), 0);
        step(1'b0, 1'b0, 8'h00, 1'b1, 1'b0);
        check("R11 request a full period after write", int'(wdt_rst_req), 1);

        // R9: good key clears the count
        idle(2000, 1'b1, 1'b0);
        step(1'b1, 1'b1, 8'hAC, 1'b0, 1'b0);
        check("R9 good key raises no request", int'(wdt_rst_req), 0);
        idle(2047, 1'b1, 1'b0);
        check("R9 count restarted by good key", int'(wdt_rst_req), 0);
        step(1'b0, 1'b0, 8'h00, 1'b1, 1'b0);
        check("R9 request a full period after key", int'(wdt_rst_req), 1);

        // R10: wrong key forces a request and clears the count
        idle(1000, 1'b1, 1'b0);
        step(1'b1, 1'b1, 8'h55, 1'b0, 1'b0);
        check("R10 wrong key request", int'(wdt_rst_req), 1);
        idle(2047, 1'b1, 1'b0);
        check("R10 count cleared by wrong key", int'(wdt_rst_req), 0);
        step(1'b0, 1'b0, 8'h00, 1'b1, 1'b0);
        check("R10 request a full period later", int'(wdt_rst_req), 1);

        // randomized phase checked against the reference state
        for (int round = 0; round < 3; round++) begin
            logic [7:0] modes [4];
            modes[0] = 8'h00; modes[1] = 8'h01; modes[2] = 8'h08; modes[3] = 8'h10;
            do_reset(1'($urandom % 2));
            step(1'b1, 1'b0, modes[$urandom % 4], 1'b0, 1'b0);
            for (int i = 0; i < 15000; i++) begin
                bit wr, a;
                logic [7:0] d;
                wr = ($urandom % 400) == 0;
                a  = 1'($urandom % 2);
                d  = (a && ($urandom % 4) != 0) ? 8'hAC : 8'($urandom);
                step(wr, a, d, ($urandom % 4) != 0, ($urandom % 2) == 0);
            end
        end

        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule